// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block decides when the processor core stops its clock for low-power operation and how it comes back. A pulse from the core reports that the sleep instruction has executed. With the idle select low the block enters full sleep, where both the core clock enable and the peripheral clock enable drop. With the idle select high it enters idle, where only the core clock stops. On entry the power-down status bit is cleared, the time-out status bit is set and a one-cycle watchdog clear is issued.

Wake sources fall into two classes. Reset-class sources are the external reset pin, brown-out and power-on. They raise a system reset request and restore both status bits. Resume-class sources are any interrupt whose flag and individual enable are both set, plus a watchdog timeout while asleep. They restart the core clock and pulse a resume strobe together with a vector flag. The vector flag tells the core to take the interrupt vector after the next instruction, and it is the global interrupt enable sampled at wake. The global enable never gates wake-up itself. A watchdog timeout while running is a reset-class event.

The state machine has five states. RUN is the core clocked. SLEEP has both clocks stopped, and IDLE has only the core clock stopped. WAKE is a one-cycle resume, and RESET is the cycles in which the system reset request is raised. The transitions are:

- enter-sleep: RUN to SLEEP or IDLE.
- abort: RUN stays in RUN when a wake is already pending.
- watchdog-reset: RUN to RESET.
- wake: SLEEP or IDLE to WAKE.
- resume: WAKE to RUN.
- reset-any: any state to RESET.
- release: RESET to RUN.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A sleep pulse in RUN with idle select 0 and no pending wake moves the block to SLEEP. From the next cycle, core clock enable is 0 and peripheral clock enable is 0.
- R2: A sleep pulse in RUN with idle select 1 and no pending wake moves the block to IDLE. Core clock enable is 0 and peripheral clock enable stays 1.
- R3: On entry to SLEEP or IDLE, the power-down status bit (1 = not powered down) becomes 0 and the time-out status bit (1 = no time-out) becomes 1. Watchdog clear is 1 for exactly one cycle.
- R4: Any of the pin, brown-out or power-on reset requests, in any state, raises the system reset request in the next cycle and holds it while the request stays high. The core clock enable is 0 in that time, both status bits return to 1, and the block returns to RUN one cycle after the request drops.
- R5: A watchdog timeout in RUN raises the system reset request for one cycle, with power-down status 1 and time-out status 0.
- R6: An interrupt wakes the block only when its flag and its individual enable are both 1. The global interrupt enable has no effect on whether wake occurs.
- R7: A resume-class wake gives exactly one WAKE cycle with core clock enable 1, resume strobe 1, watchdog clear 1, and the vector flag equal to the global interrupt enable at the wake cycle. RUN follows.
- R8: A watchdog timeout in SLEEP or IDLE wakes as in R7, sets time-out status to 0, and raises no reset request.
- R9: A sleep pulse while an enabled interrupt is pending is ignored. The core clock stays on, the status bits are unchanged and no watchdog clear is issued.
- R10: A reset-class request in the same cycle as a resume-class wake wins. No resume strobe is produced.
- R11: A watchdog timeout in the same cycle as a sleep pulse in RUN gives the R5 reset, not sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| sleep_exec | input | 1 | Sleep instruction executed pulse |
| idle_sel | input | 1 | 1 selects idle instead of full sleep |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | N_IRQ | Interrupt flags |
| irq_en | input | N_IRQ | Individual interrupt enables |
| wdt_timeout | input | 1 | Watchdog expired |
| pin_rst_req | input | 1 | External pin reset request |
| bor_req | input | 1 | Brown-out reset request |
| por_req | input | 1 | Power-on reset request |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| stat_pd_n | output | 1 | Power-down status, 0 after sleep entry |
| stat_to_n | output | 1 | Time-out status, 0 after a watchdog event |
| sys_rst_req | output | 1 | System reset request |
| resume_valid | output | 1 | Resume strobe after wake |
| resume_vec | output | 1 | Take interrupt vector after next instruction |

## Verification
Sleep and idle entries are each followed by a wake. The wakes come from an enabled interrupt with the global enable low, an enabled interrupt with it high, and a watchdog timeout, which tells the vector flag and the time-out bit apart. Flags raised without their enable, and with the global enable set, show that only the individual enable gates wake. Reset-class requests are applied from RUN, SLEEP and IDLE, one of them together with an interrupt, and each is set against a watchdog timeout while running. A sleep pulse is also given with an interrupt pending, and another together with a watchdog timeout, to exercise the two entry-blocking orders.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_IDLE  = 3'd2,
        ST_WAKE  = 3'd3,
        ST_RESET = 3'd4
    } slp_state_e;

    typedef struct packed {
        logic enter;     // RUN -> SLEEP/IDLE
        logic wake;      // SLEEP/IDLE -> WAKE
        logic wake_wdt;  // wake caused by watchdog
        logic ext_rst;   // reset-class request seen
        logic wdt_rst;   // watchdog timeout while running
    } slp_events_t;
endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             pin_rst_req,
    input  logic             bor_req,
    input  logic             por_req,
    output logic             irq_hit,
    output logic             rst_hit
);
    logic [N_IRQ-1:0] armed;

    // each line wakes only through its own enable; global enable is not used
    for (genvar i = 0; i < N_IRQ; i++) begin : g_arm
        assign armed[i] = irq_flag[i] & irq_en[i];
    end

    assign irq_hit = |armed;
    assign rst_hit = pin_rst_req | bor_req | por_req;
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_exec,
    input  logic        idle_sel,
    input  logic        irq_hit,
    input  logic        rst_hit,
    input  logic        wdt_timeout,
    output slp_events_t ev,
    output logic        cpu_clk_en,
    output logic        periph_clk_en,
    output logic        sys_rst_req,
    output logic        resume_valid
);
    slp_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and the events that accompany them
    always_comb begin
        state_d = state_q;
        ev      = '0;
        if (rst_hit) begin
            state_d    = ST_RESET;       // reset-any
            ev.ext_rst = 1'b1;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (wdt_timeout) begin
                        state_d    = ST_RESET;   // watchdog-reset
                        ev.wdt_rst = 1'b1;
                    end else if (sleep_exec && !irq_hit) begin
                        state_d  = idle_sel ? ST_IDLE : ST_SLEEP; // enter-sleep
                        ev.enter = 1'b1;
                    end
                end
                ST_SLEEP, ST_IDLE: begin
                    if (irq_hit || wdt_timeout) begin
                        state_d     = ST_WAKE;   // wake
                        ev.wake     = 1'b1;
                        ev.wake_wdt = wdt_timeout;
                    end
                end
                ST_WAKE:  state_d = ST_RUN;      // resume
                ST_RESET: state_d = ST_RUN;      // release
                default:  state_d = ST_RUN;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        sys_rst_req   = 1'b0;
        resume_valid  = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_SLEEP: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
            end
            ST_IDLE:  cpu_clk_en = 1'b0;
            ST_WAKE:  resume_valid = 1'b1;
            ST_RESET: begin
                cpu_clk_en  = 1'b0;
                sys_rst_req = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/slp_status.sv
module slp_status
    import slp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  slp_events_t ev,
    input  logic        gie,
    output logic        stat_pd_n,
    output logic        stat_to_n,
    output logic        wdt_clr,
    output logic        resume_vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_pd_n  <= 1'b1;
            stat_to_n  <= 1'b1;
            wdt_clr    <= 1'b0;
            resume_vec <= 1'b0;
        end else begin
            wdt_clr <= 1'b0;
            if (ev.ext_rst) begin
                stat_pd_n <= 1'b1;
                stat_to_n <= 1'b1;
            end else if (ev.wdt_rst) begin
                stat_pd_n <= 1'b1;
                stat_to_n <= 1'b0;
            end else if (ev.enter) begin
                stat_pd_n <= 1'b0;
                stat_to_n <= 1'b1;
                wdt_clr   <= 1'b1;
            end else if (ev.wake) begin
                wdt_clr    <= 1'b1;
                resume_vec <= gie;
                if (ev.wake_wdt) begin
                    stat_to_n <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_exec,
    input  logic             idle_sel,
    input  logic             gie,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    input  logic             pin_rst_req,
    input  logic             bor_req,
    input  logic             por_req,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             wdt_clr,
    output logic             stat_pd_n,
    output logic             stat_to_n,
    output logic             sys_rst_req,
    output logic             resume_valid,
    output logic             resume_vec
);
    logic        irq_hit;
    logic        rst_hit;
    slp_events_t ev;

    slp_wake_detect #(.N_IRQ(N_IRQ)) u_detect (
        .irq_flag   (irq_flag),
        .irq_en     (irq_en),
        .pin_rst_req(pin_rst_req),
        .bor_req    (bor_req),
        .por_req    (por_req),
        .irq_hit    (irq_hit),
        .rst_hit    (rst_hit)
    );

    slp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_exec   (sleep_exec),
        .idle_sel     (idle_sel),
        .irq_hit      (irq_hit),
        .rst_hit      (rst_hit),
        .wdt_timeout  (wdt_timeout),
        .ev           (ev),
        .cpu_clk_en   (cpu_clk_en),
        .periph_clk_en(periph_clk_en),
        .sys_rst_req  (sys_rst_req),
        .resume_valid (resume_valid)
    );

    slp_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .gie       (gie),
        .stat_pd_n (stat_pd_n),
        .stat_to_n (stat_to_n),
        .wdt_clr   (wdt_clr),
        .resume_vec(resume_vec)
    );

    // R1: peripheral clock only ever drops after a full-sleep request
    a_r1_periph_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_clk_en) |-> $past(sleep_exec && !idle_sel));

    // R3: a clock stop that is not a reset carries the entry status and clear
    a_r3_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_clk_en) && !sys_rst_req) |-> (!stat_pd_n && stat_to_n && wdt_clr));

    // R4: reset-class requests always reach the reset output
    a_r4_reset_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pin_rst_req || bor_req || por_req))
        |-> (sys_rst_req && !resume_valid));

    // R6: a resume strobe needs an enabled interrupt or a watchdog timeout
    a_r6_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_valid) |-> $past(|(irq_flag & irq_en) || wdt_timeout));

    // R7: resume cycle runs the core and clears the watchdog
    a_r7_resume_clear: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> (wdt_clr && cpu_clk_en));

    // R9: a sleep pulse with an enabled interrupt pending keeps the core running
    a_r9_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_exec && |(irq_flag & irq_en) && !wdt_timeout
         && !pin_rst_req && !bor_req && !por_req)
        |=> (cpu_clk_en && $stable(stat_pd_n)));
endmodule

// File: tb/slp_wake_ctrl_tb.sv
module slp_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_IRQ      = 8;

    typedef struct {
        logic  cpu, per, wclr, pd, to, rst, rv, vec;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_exec = 1'b0, idle_sel = 1'b0, gie = 1'b0;
    logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
    logic             wdt_timeout = 1'b0, pin_rst_req = 1'b0, bor_req = 1'b0, por_req = 1'b0;
    logic             cpu_clk_en, periph_clk_en, wdt_clr, stat_pd_n, stat_to_n;
    logic             sys_rst_req, resume_valid, resume_vec;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_wake_ctrl #(.N_IRQ(N_IRQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .idle_sel(idle_sel),
        .gie(gie), .irq_flag(irq_flag), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
        .pin_rst_req(pin_rst_req), .bor_req(bor_req), .por_req(por_req),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .wdt_clr(wdt_clr),
        .stat_pd_n(stat_pd_n), .stat_to_n(stat_to_n), .sys_rst_req(sys_rst_req),
        .resume_valid(resume_valid), .resume_vec(resume_vec)
    );

    function automatic exp_t mk(logic cpu, logic per, logic wclr, logic pd, logic to,
                                logic rst, logic rv, logic vec, string req);
        exp_t e;
        e.cpu = cpu; e.per = per; e.wclr = wclr; e.pd = pd; e.to = to;
        e.rst = rst; e.rv = rv; e.vec = vec; e.req = req;
        return e;
    endfunction

    // driver: apply one cycle of stimulus, push the expected outputs
    task automatic step(logic sl, logic idl, logic g, logic [N_IRQ-1:0] fl,
                        logic [N_IRQ-1:0] en, logic wd, logic pin, logic bor,
                        logic por, exp_t e);
        @(negedge clk);
        sleep_exec = sl; idle_sel = idl; gie = g; irq_flag = fl; irq_en = en;
        wdt_timeout = wd; pin_rst_req = pin; bor_req = bor; por_req = por;
        q.push_back(e);
    endtask

    task automatic quiet(exp_t e);
        step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, e);
    endtask

    // monitor: after each edge, compare against the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic bad;
                e = q.pop_front();
                n_checks++;
                bad = (cpu_clk_en !== e.cpu) || (periph_clk_en !== e.per) ||
                      (wdt_clr !== e.wclr) || (stat_pd_n !== e.pd) ||
                      (stat_to_n !== e.to) || (sys_rst_req !== e.rst) ||
                      (resume_valid !== e.rv) || (e.rv && resume_vec !== e.vec);
                if (bad) begin
                    n_errors++;
                    $display("FAIL %s: got cpu=%b per=%b wclr=%b pd=%b to=%b rst=%b rv=%b vec=%b exp cpu=%b per=%b wclr=%b pd=%b to=%b rst=%b rv=%b vec=%b",
                             e.req, cpu_clk_en, periph_clk_en, wdt_clr, stat_pd_n,
                             stat_to_n, sys_rst_req, resume_valid, resume_vec,
                             e.cpu, e.per, e.wclr, e.pd, e.to, e.rst, e.rv, e.vec);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_errors++;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet(mk(1,1,0,1,1,0,0,0, "reset state"));

        // R1 R3: full sleep entry
        step(1,0,0,'0,'0,0,0,0,0, mk(0,0,1,0,1,0,0,0, "R1 R3 sleep entry"));
        quiet(mk(0,0,0,0,1,0,0,0, "R3 clear is one cycle"));
        // R6: flag without its enable, global enable set: no wake
        step(0,0,1,8'h01,8'h00,0,0,0,0, mk(0,0,0,0,1,0,0,0, "R6 disabled flag ignored"));
        step(0,0,1,8'h01,8'h02,0,0,0,0, mk(0,0,0,0,1,0,0,0, "R6 mismatched enable ignored"));
        // R6 R7: enabled flag with global enable clear wakes, vector 0
        step(0,0,0,8'h01,8'h01,0,0,0,0, mk(1,1,1,0,1,0,1,0, "R6 R7 wake gie=0"));
        quiet(mk(1,1,0,0,1,0,0,0, "R7 back to run"));

        // R2: idle entry, then wake with global enable set
        step(1,1,0,'0,'0,0,0,0,0, mk(0,1,1,0,1,0,0,0, "R2 idle entry"));
        quiet(mk(0,1,0,0,1,0,0,0, "R2 idle hold"));
        step(0,0,1,8'h04,8'h04,0,0,0,0, mk(1,1,1,0,1,0,1,1, "R7 wake gie=1"));
        quiet(mk(1,1,0,0,1,0,0,0, "R7 run after vector wake"));

        // R8: watchdog wake from sleep
        step(1,0,0,'0,'0,0,0,0,0, mk(0,0,1,0,1,0,0,0, "R3 second entry"));
        step(0,0,0,'0,'0,1,0,0,0, mk(1,1,1,0,0,0,1,0, "R8 watchdog wake"));
        quiet(mk(1,1,0,0,0,0,0,0, "R8 no reset after watchdog wake"));

        // R5: watchdog while running resets
        step(0,0,0,'0,'0,1,0,0,0, mk(0,1,0,1,0,1,0,0, "R5 watchdog reset"));
        quiet(mk(1,1,0,1,0,0,0,0, "R5 release"));

        // R9: sleep pulse with enabled interrupt pending is ignored
        step(1,0,0,8'h80,8'h80,0,0,0,0, mk(1,1,0,1,0,0,0,0, "R9 entry blocked"));
        quiet(mk(1,1,0,1,0,0,0,0, "R9 still running"));

        // R4: brown-out from sleep
        step(1,0,0,'0,'0,0,0,0,0, mk(0,0,1,0,1,0,0,0, "R3 entry before reset"));
        step(0,0,0,'0,'0,0,0,1,0, mk(0,1,0,1,1,1,0,0, "R4 brown-out reset"));
        quiet(mk(1,1,0,1,1,0,0,0, "R4 release"));

        // R10: pin reset together with interrupt while idle
        step(1,1,0,'0,'0,0,0,0,0, mk(0,1,1,0,1,0,0,0, "R2 idle before reset"));
        step(0,0,1,8'h10,8'h10,0,1,0,0, mk(0,1,0,1,1,1,0,0, "R10 reset beats wake"));
        step(0,0,0,'0,'0,0,1,0,0, mk(0,1,0,1,1,1,0,0, "R4 held request"));
        quiet(mk(1,1,0,1,1,0,0,0, "R4 release after hold"));

        // R4: power-on request while running
        step(0,0,0,'0,'0,0,0,0,1, mk(0,1,0,1,1,1,0,0, "R4 power-on reset"));
        quiet(mk(1,1,0,1,1,0,0,0, "R4 run after power-on"));

        // R11: watchdog and sleep pulse together
        step(1,0,0,'0,'0,1,0,0,0, mk(0,1,0,1,0,1,0,0, "R11 watchdog beats sleep"));
        quiet(mk(1,1,0,1,0,0,0,0, "R11 release"));

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule